// File: doc/BRIEF.md
# Eye Scan Measurement Controller

This block sequences one receiver eye-margin measurement. Each bit period may carry a data-valid strobe and an error flag from the comparison sampler. Software-side configuration (rate select, horizontal phase offset, vertical voltage offset, prescale code) sits on static inputs. A start pulse moves an idle controller into an armed state. A trigger moves it on to counting. While counting, it accumulates a prescaled count of valid bits and a count of unmasked errors. The measurement finishes by itself once the sample count saturates.

The offset and divider settings drive nothing analog here. On an accepted start they are checked, split into fields and held on encoded outputs for the sampler and clock logic outside. A horizontal offset that does not fit the selected rate blocks the start. So does an offset whose sign bit is inconsistent. Each unmasked error seen while armed or counting is also reported as a single-cycle event pulse.

Top module: `eyescan_ctrl`

## Requirements
- R1: After reset, state_o is 0 (idle), both counters are 0, and err_event and done are 0. State codes: 0 idle, 1 armed, 2 counting, 3 done.
- R2: A start seen in idle with cfg_err low moves the machine to armed on the next edge. That edge clears both counters and captures the configuration. In any other state, start changes nothing.
- R3: The armed state holds until trig is sampled high. The next edge then moves the machine to counting.
- R4: err_event is high for one cycle, the cycle after each edge where bit_valid, bit_err and !err_mask hold together in the armed or counting state. It is low at all other times.
- R5: In counting, samp_cnt rises by one for every 2^(1+prescale) cycles with bit_valid high. The prescale code is the one captured at start.
- R6: err_cnt rises by one for each edge in counting where bit_valid and bit_err are high and err_mask is low. Errors in any other state are not counted.
- R7: Both counters stop at all ones (16'hFFFF by default) and never wrap.
- R8: When samp_cnt is all ones in counting, the next edge enters done. done is high for that one cycle, then the machine returns to idle with both counts held.
- R9: rate_o encodes the captured divider as 0 (divide 1), 1 (divide 2), 2 (divide 4) or 3 (divide 8). rate_sel codes 1, 2, 3 and 4 select 0, 1, 2 and 3. Codes 0 and 5 to 7 select the DEF_RATE parameter.
- R10: cfg_err is high, combinationally from the inputs, when horz_off[10:0] read as a signed count lies outside ±(32·2^r). Here r is the rate index that rate_sel selects.
- R11: cfg_err is also high when horz_off[11] differs from the sign of horz_off[10:0]. With cfg_err high, start leaves the machine idle.
- R12: On an accepted start, phase_o takes horz_off[10:0], vmag_o takes vert_off[6:0] and vneg_o takes vert_off[7] (1 means negative). vert_off[8] is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate user clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | Current bit carries a scan sample |
| bit_err | input | 1 | Scan sample disagreed with the data sample |
| err_mask | input | 1 | Ignore the error flag this bit |
| start | input | 1 | Begin a measurement (idle only) |
| trig | input | 1 | Trigger event, leaves armed |
| rate_sel | input | 3 | Divider select code |
| horz_off | input | 12 | Phase offset, bit 11 sign unification |
| vert_off | input | 9 | Vertical offset, sign bit 7, magnitude 6:0 |
| prescale | input | 5 | Sample prescale code p, factor 2^(1+p) |
| state_o | output | 2 | Controller state |
| err_event | output | 1 | One-cycle pulse per unmasked error |
| samp_cnt | output | CNT_W | Prescaled sample count |
| err_cnt | output | CNT_W | Error count |
| done | output | 1 | Measurement finished |
| cfg_err | output | 1 | Horizontal offset invalid for the rate |
| rate_o | output | 2 | Captured divider index |
| phase_o | output | 11 | Captured phase count |
| vmag_o | output | 7 | Captured vertical magnitude |
| vneg_o | output | 1 | Captured vertical sign |

## Verification
The counting path gets a steady run of valid bits under a factor-8 prescale. That shows whether the divider uses 2^(1+p) rather than 2^p. A long run with errors on every bit then drives both counters to saturation and into done, which separates wrap from stop and shows the one-cycle done exit. Offsets right at and one past each rate limit, including a wrong sign bit and unused rate codes, test the range check against the per-rate window. A long random stretch with masked and unmasked errors, stray starts and triggers is compared each cycle against a behavioural model. It exposes event pulses outside armed and counting, and starts acted on outside idle.

// File: rtl/eyescan_pkg.sv
package eyescan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_COUNT = 2'd2,
    ST_DONE  = 2'd3
  } scan_state_t;

  localparam int unsigned RATE_N   = 4;
  localparam int unsigned HALF_UI0 = 32;
endpackage

// File: rtl/eyescan_cfg.sv
module eyescan_cfg
  import eyescan_pkg::*;
#(
  parameter int unsigned HOFF_W   = 12,
  parameter int unsigned DEF_RATE = 0
) (
  input  logic [2:0]        rate_sel,
  input  logic [HOFF_W-1:0] horz,
  output logic [1:0]        rate_idx,
  output logic              bad
);
  localparam int unsigned PH_W = HOFF_W - 1;

  logic signed [PH_W:0] lim_tab [RATE_N];
  logic signed [PH_W:0] ph;
  logic signed [PH_W:0] lim;
  logic signed [PH_W:0] nlim;
  logic                 lo_bad;
  logic                 hi_bad;
  logic                 sign_bad;

  for (genvar r = 0; r < RATE_N; r++) begin : g_lim
    assign lim_tab[r] = (PH_W+1)'(HALF_UI0 << r);
  end

  always_comb begin
    case (rate_sel)
      3'd1:    rate_idx = 2'd0;
      3'd2:    rate_idx = 2'd1;
      3'd3:    rate_idx = 2'd2;
      3'd4:    rate_idx = 2'd3;
      default: rate_idx = DEF_RATE[1:0];
    endcase
  end

  always_comb begin
    ph       = signed'({horz[PH_W-1], horz[PH_W-1:0]});
    lim      = lim_tab[rate_idx];
    nlim     = -lim;
    lo_bad   = ph < nlim;
    hi_bad   = ph > lim;
    sign_bad = horz[PH_W] != horz[PH_W-1];
    bad      = lo_bad | hi_bad | sign_bad;
  end
endmodule

// File: rtl/eyescan_presc.sv
module eyescan_presc #(
  parameter int unsigned PRE_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [PRE_W-1:0] code,
  output logic             tick
);
  localparam int unsigned PC_W = (1 << PRE_W) + 1;

  logic [PC_W-1:0]  cnt_q;
  logic [PC_W-1:0]  cnt_d;
  logic [PC_W-1:0]  lim;
  logic [PRE_W:0]   sh;

  always_comb begin
    sh   = {1'b0, code} + 1'b1;
    lim  = ({{(PC_W-1){1'b0}}, 1'b1} << sh) - 1'b1;
    tick = en && (cnt_q == lim);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = '0;
    else if (en)   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/eyescan_satcnt.sv
module eyescan_satcnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (clr)                   q_d = '0;
    else if (inc && q != TOP)  q_d = q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/eyescan_ctrl.sv
module eyescan_ctrl
  import eyescan_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned PRE_W    = 5,
  parameter int unsigned HOFF_W   = 12,
  parameter int unsigned VOFF_W   = 9,
  parameter int unsigned DEF_RATE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_valid,
  input  logic              bit_err,
  input  logic              err_mask,
  input  logic              start,
  input  logic              trig,
  input  logic [2:0]        rate_sel,
  input  logic [HOFF_W-1:0] horz_off,
  input  logic [VOFF_W-1:0] vert_off,
  input  logic [PRE_W-1:0]  prescale,
  output logic [1:0]        state_o,
  output logic              err_event,
  output logic [CNT_W-1:0]  samp_cnt,
  output logic [CNT_W-1:0]  err_cnt,
  output logic              done,
  output logic              cfg_err,
  output logic [1:0]        rate_o,
  output logic [HOFF_W-2:0] phase_o,
  output logic [VOFF_W-3:0] vmag_o,
  output logic              vneg_o
);
  localparam int unsigned PH_W  = HOFF_W - 1;
  localparam int unsigned MAG_W = VOFF_W - 2;
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  scan_state_t      state_q;
  scan_state_t      state_d;
  logic             accept;
  logic             counting;
  logic             live;
  logic             hit;
  logic             samp_tick;
  logic             evt_d;
  logic             evt_q;
  logic [1:0]       rate_idx;
  logic             cfg_bad;
  logic [1:0]       rate_q;
  logic [PH_W-1:0]  phase_q;
  logic [MAG_W-1:0] vmag_q;
  logic             vneg_q;
  logic [PRE_W-1:0] presc_q;

  eyescan_cfg #(
    .HOFF_W   (HOFF_W),
    .DEF_RATE (DEF_RATE)
  ) u_cfg (
    .rate_sel (rate_sel),
    .horz     (horz_off),
    .rate_idx (rate_idx),
    .bad      (cfg_bad)
  );

  always_comb begin
    accept   = (state_q == ST_IDLE) && start && !cfg_bad;
    counting = (state_q == ST_COUNT);
    live     = (state_q == ST_ARMED) || counting;
    hit      = bit_valid && bit_err && !err_mask;
    evt_d    = live && hit;
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (accept) state_d = ST_ARMED;
      ST_ARMED: if (trig) state_d = ST_COUNT;
      ST_COUNT: if (samp_cnt == CNT_TOP) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      evt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      evt_q   <= evt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q  <= '0;
      phase_q <= '0;
      vmag_q  <= '0;
      vneg_q  <= 1'b0;
      presc_q <= '0;
    end else if (accept) begin
      rate_q  <= rate_idx;
      phase_q <= horz_off[PH_W-1:0];
      vmag_q  <= vert_off[MAG_W-1:0];
      vneg_q  <= vert_off[MAG_W];
      presc_q <= prescale;
    end
  end

  eyescan_presc #(
    .PRE_W (PRE_W)
  ) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .en    (counting && bit_valid),
    .code  (presc_q),
    .tick  (samp_tick)
  );

  eyescan_satcnt #(
    .W (CNT_W)
  ) u_samp (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .inc   (samp_tick),
    .q     (samp_cnt)
  );

  eyescan_satcnt #(
    .W (CNT_W)
  ) u_errc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .inc   (counting && hit),
    .q     (err_cnt)
  );

  assign state_o   = state_q;
  assign err_event = evt_q;
  assign done      = (state_q == ST_DONE);
  assign cfg_err   = cfg_bad;
  assign rate_o    = rate_q;
  assign phase_o   = phase_q;
  assign vmag_o    = vmag_q;
  assign vneg_o    = vneg_q;
endmodule

// File: rtl/eyescan_ctrl_chk.sv
module eyescan_ctrl_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_valid,
  input logic             bit_err,
  input logic             err_mask,
  input logic             trig,
  input logic [1:0]       state_o,
  input logic             err_event,
  input logic [CNT_W-1:0] samp_cnt,
  input logic [CNT_W-1:0] err_cnt,
  input logic             done,
  input logic             cfg_err
);
  assert_evt_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_event |-> ($past(state_o) == 2'd1 || $past(state_o) == 2'd2));

  assert_evt_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_event |-> $past(bit_valid && bit_err && !err_mask));

  assert_trig_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd1 && trig) |=> state_o == 2'd2);

  assert_armed_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd1 && !trig) |=> state_o == 2'd1);

  assert_cfg_block_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0 && cfg_err) |=> state_o == 2'd0);

  assert_samp_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != 2'd0 |=> samp_cnt >= $past(samp_cnt));

  assert_err_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != 2'd0 |=> err_cnt >= $past(err_cnt));

  assert_done_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2 && samp_cnt == '1) |=> done);

  assert_done_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (state_o == 2'd0 && !done));
endmodule

bind eyescan_ctrl eyescan_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_valid (bit_valid),
  .bit_err   (bit_err),
  .err_mask  (err_mask),
  .trig      (trig),
  .state_o   (state_o),
  .err_event (err_event),
  .samp_cnt  (samp_cnt),
  .err_cnt   (err_cnt),
  .done      (done),
  .cfg_err   (cfg_err)
);

// File: tb/eyescan_ctrl_test.sv
`timescale 1ns/1ps
module eyescan_ctrl_test;
  localparam int CW   = 6;
  localparam int TOPV = (1 << CW) - 1;
  localparam int DEFR = 2;

  logic          clk;
  logic          rst_n;
  logic          bit_valid, bit_err, err_mask, start, trig;
  logic [2:0]    rate_sel;
  logic [11:0]   horz_off;
  logic [8:0]    vert_off;
  logic [4:0]    prescale;
  logic [1:0]    state_o;
  logic          err_event, done, cfg_err, vneg_o;
  logic [CW-1:0] samp_cnt, err_cnt;
  logic [1:0]    rate_o;
  logic [10:0]   phase_o;
  logic [6:0]    vmag_o;

  int total = 0;
  int bad   = 0;

  eyescan_ctrl #(.CNT_W(CW), .DEF_RATE(DEFR)) uut (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_err(bit_err),
    .err_mask(err_mask), .start(start), .trig(trig), .rate_sel(rate_sel),
    .horz_off(horz_off), .vert_off(vert_off), .prescale(prescale),
    .state_o(state_o), .err_event(err_event), .samp_cnt(samp_cnt),
    .err_cnt(err_cnt), .done(done), .cfg_err(cfg_err), .rate_o(rate_o),
    .phase_o(phase_o), .vmag_o(vmag_o), .vneg_o(vneg_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int ref_rate(input logic [2:0] r);
    case (r)
      3'd1: return 0;
      3'd2: return 1;
      3'd3: return 2;
      3'd4: return 3;
      default: return DEFR;
    endcase
  endfunction

  function automatic bit ref_bad(input logic [2:0] r, input logic [11:0] h);
    int v;
    int lim;
    v   = int'(h[10:0]);
    if (v >= 1024) v = v - 2048;
    lim = 32 * (1 << ref_rate(r));
    return (v < -lim) || (v > lim) || (h[11] != (v < 0));
  endfunction

  // behavioural reference model
  int     m_st, m_samp, m_err, m_rate, m_phase, m_vmag, m_vneg, m_pres;
  longint m_pre;
  bit     m_evt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_samp = 0; m_err = 0; m_pre = 0; m_evt = 0;
      m_rate = 0; m_phase = 0; m_vmag = 0; m_vneg = 0; m_pres = 0;
    end else begin
      bit h;
      h     = bit_valid && bit_err && !err_mask;
      m_evt = h && (m_st == 1 || m_st == 2);
      case (m_st)
        0: if (start && !ref_bad(rate_sel, horz_off)) begin
             m_st = 1; m_samp = 0; m_err = 0; m_pre = 0;
             m_rate = ref_rate(rate_sel); m_phase = int'(horz_off[10:0]);
             m_vmag = int'(vert_off[6:0]); m_vneg = int'(vert_off[7]);
             m_pres = int'(prescale);
           end
        1: if (trig) m_st = 2;
        2: begin
             int next_st;
             next_st = (m_samp == TOPV) ? 3 : 2;
             if (bit_valid) begin
               if (m_pre == (longint'(1) << (m_pres + 1)) - 1) begin
                 m_pre = 0;
                 if (m_samp < TOPV) m_samp++;
               end else m_pre++;
             end
             if (h && m_err < TOPV) m_err++;
             m_st = next_st;
           end
        default: m_st = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(state_o == m_st,      "R3 state",      state_o, m_st);
      check(err_event == m_evt,   "R4 err_event",  err_event, m_evt);
      check(samp_cnt == m_samp,   "R5 samp_cnt",   samp_cnt, m_samp);
      check(err_cnt == m_err,     "R6 err_cnt",    err_cnt, m_err);
      check(done == (m_st == 3),  "R8 done",       done, m_st == 3);
      check(cfg_err == ref_bad(rate_sel, horz_off), "R10 cfg_err", cfg_err, ref_bad(rate_sel, horz_off));
      check(rate_o == m_rate,     "R9 rate_o",     rate_o, m_rate);
      check(phase_o == m_phase,   "R12 phase_o",   phase_o, m_phase);
      check(vmag_o == m_vmag,     "R12 vmag_o",    vmag_o, m_vmag);
      check(vneg_o == m_vneg,     "R12 vneg_o",    vneg_o, m_vneg);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bit_valid = 0; bit_err = 0; err_mask = 0; start = 0; trig = 0;
    rate_sel = 3'd1; horz_off = 12'h000; vert_off = 9'h000; prescale = 5'd0;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    check(state_o == 2'd0 && samp_cnt == 0 && err_cnt == 0 && !done && !err_event,
          "R1 reset state", state_o, 0);

    // R11 sign bit disagrees
    horz_off = 12'h805; #1;
    check(cfg_err == 1'b1, "R11 sign mismatch", cfg_err, 1);
    start = 1'b1; step(1); start = 1'b0;
    check(state_o == 2'd0, "R11 start blocked", state_o, 0);

    // R10 range edges
    horz_off = 12'd33; #1;  check(cfg_err == 1'b1, "R10 full +33", cfg_err, 1);
    horz_off = 12'd32; #1;  check(cfg_err == 1'b0, "R10 full +32", cfg_err, 0);
    rate_sel = 3'd4; horz_off = 12'd257; #1; check(cfg_err == 1'b1, "R10 octal +257", cfg_err, 1);
    horz_off = 12'hF00; #1; check(cfg_err == 1'b0, "R10 octal -256", cfg_err, 0);
    rate_sel = 3'd7; #1;    check(cfg_err == 1'b1, "R9 R10 code7 default quarter -256", cfg_err, 1);
    horz_off = 12'hF80; #1; check(cfg_err == 1'b0, "R9 R10 code7 default quarter -128", cfg_err, 0);

    // R2 accepted start with capture
    rate_sel = 3'd4; horz_off = 12'hF00; vert_off = 9'h1A5; prescale = 5'd2;
    start = 1'b1; step(1); start = 1'b0;
    check(state_o == 2'd1, "R2 armed after start", state_o, 1);
    check(rate_o == 2'd3 && phase_o == 11'h700, "R9 R12 captured rate/phase", phase_o, 11'h700);
    check(vmag_o == 7'h25 && vneg_o == 1'b1, "R12 captured vertical", vmag_o, 7'h25);
    start = 1'b1; step(1); start = 1'b0;
    check(state_o == 2'd1, "R2 start ignored when armed", state_o, 1);

    // R4/R6 errors in armed: pulse, not counted; mask suppresses
    bit_valid = 1; bit_err = 1; step(1);
    check(err_event == 1'b1, "R4 event in armed", err_event, 1);
    check(err_cnt == 0, "R6 no count in armed", err_cnt, 0);
    err_mask = 1; step(1);
    check(err_event == 1'b0, "R4 masked error", err_event, 0);
    bit_valid = 0; bit_err = 0; err_mask = 0;

    // R3 trigger
    trig = 1; step(1); trig = 0;
    check(state_o == 2'd2, "R3 trig to count", state_o, 2);

    // R5 prescale factor 8
    bit_valid = 1; step(16); bit_valid = 0;
    check(samp_cnt == 2, "R5 16 bits at factor 8", samp_cnt, 2);

    // R7/R8 saturation and done
    bit_valid = 1; bit_err = 1;
    for (int i = 0; i < 2000 && !done; i++) step(1);
    check(done == 1'b1, "R8 done reached", done, 1);
    check(samp_cnt == TOPV, "R7 samp saturated", samp_cnt, TOPV);
    check(err_cnt == TOPV, "R7 err saturated", err_cnt, TOPV);
    step(1);
    check(state_o == 2'd0 && !done, "R8 back to idle", state_o, 0);
    check(samp_cnt == TOPV && err_cnt == TOPV, "R8 counts held", samp_cnt, TOPV);
    bit_valid = 0; bit_err = 0;

    // random stretch compared against the model
    for (int i = 0; i < 6000; i++) begin
      bit_valid = $urandom_range(0, 3) != 0;
      bit_err   = $urandom_range(0, 3) == 0;
      err_mask  = $urandom_range(0, 4) == 0;
      start     = $urandom_range(0, 20) == 0;
      trig      = $urandom_range(0, 15) == 0;
      rate_sel  = 3'($urandom_range(0, 7));
      prescale  = 5'($urandom_range(0, 1));
      vert_off  = 9'($urandom);
      horz_off  = ($urandom_range(0, 3) == 0) ? 12'($urandom)
                                              : 12'($signed(12'($urandom_range(0, 64))) - 12'sd32);
      step(1);
    end
    step(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule